// File: doc/BRIEF.md
# Idle-Slot Link Self-Test Port

This block sits beside one port of a packet-switched mesh router and tests the wires between that port and its neighbour while traffic is flowing. It needs no dedicated test time. On the sending side, any cycle in which the router has no flit to send is filled with a test word from a fixed pattern sequence. On the receiving side, every word that arrives in an idle link cycle is registered and then compared with the test word the far end should have sent in that slot.

A mismatch marks this port's input as faulty. The block then places a reserved fault code on its own outgoing link, so that the neighbour learns which side failed. When the fault code arrives from upstream, the block instead marks the neighbour's output port as faulty. Both flags stay set until they are cleared.

Two pattern sets are offered. The short set is one word and its bitwise complement, which is enough for stuck-at faults. The full set walks through one address-bit pattern per bit of the link index, each followed by its complement, for bridging and delay faults. Sender and receiver count only idle cycles, so both ends keep their place in the sequence across busy periods.

Top module: `link_bist_port`

## Requirements
- R1: When `loc_put` is high at a clock edge, after that edge `lnk_out_put` is 1 and `lnk_out_data` equals the `loc_flit` sampled at that edge.
- R2: When `loc_put` is low at a clock edge, after that edge `lnk_out_put` is 0 and `lnk_out_data` carries the current test word. Test word j has bit i equal to bit (j/2) of the number i, inverted when j is odd. For the default width of 8 the sequence is AA, 55, CC, 33, F0, 0F (hex).
- R3: With `full_mode` = 1 the index cycles through 0 .. 2*log2(W)-1. With `full_mode` = 0 it cycles through 0 and 1 only. An index at or above the last value of the selected set wraps to 0 on its next step.
- R4: The sending index advances once per idle cycle, including a cycle that carries the fault code. It holds through busy cycles, so the test position survives traffic.
- R5: A word received with `lnk_in_put` = 0 that equals the fault code (default 81 hex) sets `up_out_fault`. The flag appears after the second rising edge that follows the word's presence on the link.
- R6: A word received with `lnk_in_put` = 0 that is neither the start word (default 7E hex), nor the fault code, nor the expected test word sets `loc_in_fault`, with the same two-edge latency. Words received with `lnk_in_put` = 1 are never checked.
- R7: The receive index advances once for every idle word received, whatever its value, using the same wrap rule as the sender. It holds while received words are busy.
- R8: After a local input mismatch is detected, the next cycle in which `loc_put` is low sends the fault code in place of the test word. Detections made before the code has gone out merge into one code.
- R9: Both fault flags are sticky until `fault_clr` is high at an edge. A clear also cancels an unsent fault code, and it wins over a detection at the same edge.
- R10: While reset is asserted, `lnk_out_put`, `lnk_out_data`, `up_out_fault` and `loc_in_fault` are all 0, and both indices restart at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| full_mode | input | 1 | 1 = full bridging/delay set, 0 = stuck-at pair |
| fault_clr | input | 1 | Synchronous clear of fault flags and pending code |
| loc_put | input | 1 | Router presents a flit this cycle |
| loc_flit | input | W | Flit from the router |
| lnk_out_put | output | 1 | Outgoing link valid |
| lnk_out_data | output | W | Outgoing link word |
| lnk_in_put | input | 1 | Incoming link valid |
| lnk_in_data | input | W | Incoming link word |
| up_out_fault | output | 1 | Sticky: neighbour's output port reported faulty |
| loc_in_fault | output | 1 | Sticky: this port's input found faulty |

## Verification
Several properties are checked on every cycle. Flits pass through unchanged and idle slots drop the valid line. A pending code goes out in the next idle slot. Both indices hold through busy cycles and stay in range. The flags are sticky and clear in one cycle. The exact pattern order, the wrap at each set length, the alignment of the two indices across mixed traffic, and the choice between the upstream and local verdicts depend on history. Only the bench shows these, by comparing every output against its own model under directed faults and seeded random traffic.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    typedef enum logic [1:0] {
        LB_SKIP     = 2'd0,
        LB_PASS     = 2'd1,
        LB_UPSTREAM = 2'd2,
        LB_LOCAL    = 2'd3
    } lbist_verdict_e;

    // Step a pattern index, wrapping at or past the last slot of the set
    function automatic int unsigned lbist_step_idx(int unsigned cur, int unsigned last);
        return (cur >= last) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/lbist_pattern_gen.sv
module lbist_pattern_gen #(
    parameter int unsigned W  = 8,
    parameter int unsigned IW = 3
) (
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  pat
);
    logic [IW-1:0] addr_bit;

    assign addr_bit = idx >> 1;

    // bit i of the word is address bit (idx/2) of i, complemented on odd idx
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign pat[i] = (((i >> int'(addr_bit)) & 1) == 1) ^ idx[0];
    end
endmodule

// File: rtl/lbist_tx.sv
module lbist_tx #(
    parameter int unsigned W          = 8,
    parameter int unsigned IW         = 3,
    parameter int unsigned LAST_FULL  = 5,
    parameter logic [W-1:0] FAULT_CODE = 'h81
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         full_mode,
    input  logic         fault_clr,
    input  logic         code_req,
    input  logic         loc_put,
    input  logic [W-1:0] loc_flit,
    output logic         lnk_out_put,
    output logic [W-1:0] lnk_out_data
);
    import lbist_pkg::*;

    typedef struct packed {
        logic          put;
        logic [W-1:0]  data;
        logic [IW-1:0] idx;
        logic          pend;
    } tx_state_t;

    tx_state_t     st_d, st_q;
    logic [W-1:0]  pat;
    logic [IW-1:0] idx_nxt;

    lbist_pattern_gen #(.W(W), .IW(IW)) u_pat (
        .idx (st_q.idx),
        .pat (pat)
    );

    always_comb begin
        idx_nxt = IW'(lbist_step_idx(int'(st_q.idx), full_mode ? LAST_FULL : 1));
        st_d    = st_q;
        if (loc_put) begin
            st_d.put  = 1'b1;
            st_d.data = loc_flit;
        end else begin
            st_d.put  = 1'b0;
            st_d.data = st_q.pend ? FAULT_CODE : pat;
            st_d.idx  = idx_nxt;
        end
        // pending code survives busy cycles, leaves with the first idle one
        st_d.pend = fault_clr ? 1'b0 : (code_req | (st_q.pend & loc_put));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lnk_out_put  = st_q.put;
    assign lnk_out_data = st_q.data;

    a_r1_flit_pass: assert property (@(posedge clk) disable iff (!rst_n)
        loc_put |=> (lnk_out_put && lnk_out_data == $past(loc_flit)));

    a_r2_idle_drops_put: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_put |=> !lnk_out_put);

    a_r8_code_in_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !loc_put) |=> (lnk_out_data == FAULT_CODE));

    a_r4_busy_holds_index: assert property (@(posedge clk) disable iff (!rst_n)
        loc_put |=> $stable(st_q.idx));

    a_r3_tx_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.idx) <= LAST_FULL);
endmodule

// File: rtl/lbist_rx.sv
module lbist_rx #(
    parameter int unsigned W          = 8,
    parameter int unsigned IW         = 3,
    parameter int unsigned LAST_FULL  = 5,
    parameter logic [W-1:0] SOP_WORD   = 'h7E,
    parameter logic [W-1:0] FAULT_CODE = 'h81
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         full_mode,
    input  logic         fault_clr,
    input  logic         lnk_in_put,
    input  logic [W-1:0] lnk_in_data,
    output logic         up_out_fault,
    output logic         loc_in_fault,
    output logic         local_fault_evt
);
    import lbist_pkg::*;

    typedef struct packed {
        logic          cap_put;
        logic [W-1:0]  cap_data;
        logic [IW-1:0] idx;
        logic          up_flt;
        logic          in_flt;
    } rx_state_t;

    rx_state_t      st_d, st_q;
    logic [W-1:0]   expect_word;
    lbist_verdict_e verdict;

    lbist_pattern_gen #(.W(W), .IW(IW)) u_pat (
        .idx (st_q.idx),
        .pat (expect_word)
    );

    // the compared word was registered a cycle earlier, so a bit that
    // settles late after a pattern change shows up as a mismatch
    always_comb begin
        if (st_q.cap_put) begin
            verdict = LB_SKIP;
        end else if (st_q.cap_data == FAULT_CODE) begin
            verdict = LB_UPSTREAM;
        end else if (st_q.cap_data != SOP_WORD && st_q.cap_data != expect_word) begin
            verdict = LB_LOCAL;
        end else begin
            verdict = LB_PASS;
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.cap_put  = lnk_in_put;
        st_d.cap_data = lnk_in_data;
        if (verdict != LB_SKIP) begin
            st_d.idx = IW'(lbist_step_idx(int'(st_q.idx), full_mode ? LAST_FULL : 1));
        end
        if (verdict == LB_UPSTREAM) st_d.up_flt = 1'b1;
        if (verdict == LB_LOCAL)    st_d.in_flt = 1'b1;
        if (fault_clr) begin
            st_d.up_flt = 1'b0;
            st_d.in_flt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cap_put <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign up_out_fault    = st_q.up_flt;
    assign loc_in_fault    = st_q.in_flt;
    assign local_fault_evt = (verdict == LB_LOCAL);

    a_r9_sticky_local: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_in_fault && !fault_clr) |=> loc_in_fault);

    a_r9_sticky_upstream: assert property (@(posedge clk) disable iff (!rst_n)
        (up_out_fault && !fault_clr) |=> up_out_fault);

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr |=> (!up_out_fault && !loc_in_fault));

    a_r7_busy_holds_index: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cap_put |=> $stable(st_q.idx));

    a_r5_code_flags_upstream: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.cap_put && st_q.cap_data == FAULT_CODE && !fault_clr) |=> up_out_fault);

    a_r3_rx_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.idx) <= LAST_FULL);
endmodule

// File: rtl/link_bist_port.sv
module link_bist_port #(
    parameter int unsigned W          = 8,
    parameter logic [W-1:0] SOP_WORD   = 'h7E,
    parameter logic [W-1:0] FAULT_CODE = 'h81
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         full_mode,
    input  logic         fault_clr,
    input  logic         loc_put,
    input  logic [W-1:0] loc_flit,
    output logic         lnk_out_put,
    output logic [W-1:0] lnk_out_data,
    input  logic         lnk_in_put,
    input  logic [W-1:0] lnk_in_data,
    output logic         up_out_fault,
    output logic         loc_in_fault
);
    localparam int unsigned ADDR_BITS = (W > 1) ? $clog2(W) : 1;
    localparam int unsigned NPAT      = 2 * ADDR_BITS;
    localparam int unsigned IW        = $clog2(NPAT);
    localparam int unsigned LAST_FULL = NPAT - 1;

    logic code_req;

    lbist_tx #(
        .W(W), .IW(IW), .LAST_FULL(LAST_FULL), .FAULT_CODE(FAULT_CODE)
    ) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .full_mode    (full_mode),
        .fault_clr    (fault_clr),
        .code_req     (code_req),
        .loc_put      (loc_put),
        .loc_flit     (loc_flit),
        .lnk_out_put  (lnk_out_put),
        .lnk_out_data (lnk_out_data)
    );

    lbist_rx #(
        .W(W), .IW(IW), .LAST_FULL(LAST_FULL),
        .SOP_WORD(SOP_WORD), .FAULT_CODE(FAULT_CODE)
    ) u_rx (
        .clk             (clk),
        .rst_n           (rst_n),
        .full_mode       (full_mode),
        .fault_clr       (fault_clr),
        .lnk_in_put      (lnk_in_put),
        .lnk_in_data     (lnk_in_data),
        .up_out_fault    (up_out_fault),
        .loc_in_fault    (loc_in_fault),
        .local_fault_evt (code_req)
    );

    // reserved words must never collide with a test word
    initial begin
        for (int j = 0; j < int'(NPAT); j++) begin
            logic [W-1:0] w;
            for (int b = 0; b < int'(W); b++) begin
                w[b] = (((b >> (j / 2)) & 1) == 1) ^ ((j % 2) == 1);
            end
            a_r2_reserved_distinct: assert (w != SOP_WORD && w != FAULT_CODE && SOP_WORD != FAULT_CODE)
                else $error("reserved word equals test word %0d", j);
        end
    end
endmodule

// File: tb/tb_link_bist_port.sv
`timescale 1ns/1ps
module tb_link_bist_port;
    localparam int unsigned W   = 8;
    localparam logic [W-1:0] SOP = 8'h7E;
    localparam logic [W-1:0] FC  = 8'h81;
    localparam int unsigned NP  = 2 * $clog2(W);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         full_mode = 1'b1;
    logic         fault_clr = 1'b0;
    logic         loc_put = 1'b0;
    logic [W-1:0] loc_flit = '0;
    logic         lnk_out_put;
    logic [W-1:0] lnk_out_data;
    logic         lnk_in_put = 1'b1;
    logic [W-1:0] lnk_in_data = '0;
    logic         up_out_fault;
    logic         loc_in_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic         m_put = 0, m_cap_put = 1, m_pend = 0, m_up = 0, m_in = 0, m_sent = 0;
    logic [W-1:0] m_data = '0, m_cap_data = '0;
    int unsigned  m_txi = 0, m_rxi = 0, s_idx = 0;

    always #2 clk = ~clk;

    link_bist_port #(.W(W), .SOP_WORD(SOP), .FAULT_CODE(FC)) dut (
        .clk(clk), .rst_n(rst_n), .full_mode(full_mode), .fault_clr(fault_clr),
        .loc_put(loc_put), .loc_flit(loc_flit),
        .lnk_out_put(lnk_out_put), .lnk_out_data(lnk_out_data),
        .lnk_in_put(lnk_in_put), .lnk_in_data(lnk_in_data),
        .up_out_fault(up_out_fault), .loc_in_fault(loc_in_fault)
    );

    function automatic logic [W-1:0] bf_pat(int unsigned j);
        logic [W-1:0] w;
        for (int b = 0; b < int'(W); b++) w[b] = (((b >> (j / 2)) & 1) == 1) ^ ((j % 2) == 1);
        return w;
    endfunction

    function automatic int unsigned bf_next(int unsigned j, logic full);
        int unsigned last = full ? NP - 1 : 1;
        return (j >= last) ? 0 : j + 1;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // advance the model by one edge using current inputs, then compare
    task automatic step(string ph);
        logic evt = 1'b0;
        bit   clr = fault_clr;
        m_sent = 1'b0;
        if (loc_put) begin
            m_put = 1'b1; m_data = loc_flit;
        end else begin
            m_put = 1'b0;
            if (m_pend) begin m_data = FC; m_sent = 1'b1; end
            else m_data = bf_pat(m_txi);
            m_txi = bf_next(m_txi, full_mode);
        end
        if (!m_cap_put) begin
            if (m_cap_data == FC) m_up = 1'b1;
            else if (m_cap_data != SOP && m_cap_data != bf_pat(m_rxi)) begin
                m_in = 1'b1; evt = 1'b1;
            end
            m_rxi = bf_next(m_rxi, full_mode);
        end
        if (clr) begin m_up = 0; m_in = 0; m_pend = 0; end
        else m_pend = evt | (m_pend & ~m_sent);
        m_cap_put = lnk_in_put; m_cap_data = lnk_in_data;
        @(posedge clk);
        @(negedge clk);
        chk($sformatf("%s put %s", m_put ? "R1" : "R2", ph), 64'(lnk_out_put), 64'(m_put));
        chk($sformatf("%s data %s", m_put ? "R1" : (m_sent ? "R8" : "R2"), ph),
            64'(lnk_out_data), 64'(m_data));
        chk($sformatf("%s upstream %s", clr ? "R9" : "R5", ph), 64'(up_out_fault), 64'(m_up));
        chk($sformatf("%s local %s", clr ? "R9" : "R6", ph), 64'(loc_in_fault), 64'(m_in));
    endtask

    // drive the expected next test word, optionally corrupted
    task automatic link_pat(logic [W-1:0] flip);
        lnk_in_put  = 1'b0;
        lnk_in_data = bf_pat(s_idx) ^ flip;
        s_idx = bf_next(s_idx, full_mode);
    endtask

    task automatic link_word(logic [W-1:0] w);
        lnk_in_put = 1'b0; lnk_in_data = w;
        s_idx = bf_next(s_idx, full_mode);
    endtask

    task automatic all_busy(int n, string ph);
        for (int k = 0; k < n; k++) begin
            loc_put = 1; loc_flit = W'($urandom); lnk_in_put = 1; lnk_in_data = W'($urandom);
            fault_clr = 0;
            step(ph);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        #1;
        chk("R10 reset put", 64'(lnk_out_put), 0);
        chk("R10 reset data", 64'(lnk_out_data), 0);
        chk("R10 reset upstream", 64'(up_out_fault), 0);
        chk("R10 reset local", 64'(loc_in_fault), 0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;

        // R2 R3: full sequence with all-idle traffic, two laps
        for (int k = 0; k < 2 * int'(NP) + 1; k++) begin
            loc_put = 0; fault_clr = 0; link_pat('0);
            step("R3 full idle");
        end
        // R4 R7: interleaved busy keeps position
        for (int k = 0; k < 20; k++) begin
            loc_put = k[0]; loc_flit = W'($urandom); fault_clr = 0;
            if (k % 3 == 0) begin lnk_in_put = 1; lnk_in_data = FC; end
            else link_pat('0);
            step("R4 R7 interleave");
        end
        // R6 R8: corrupted word, then code waits through busy slot
        loc_put = 0; link_pat(8'h04); step("R6 inject");
        loc_put = 1; link_pat('0); step("R6 detect");
        loc_put = 1; link_pat('0); step("R8 busy wait");
        loc_put = 0; link_pat('0); step("R8 code out");
        loc_put = 0; link_pat('0); step("R8 code once");
        // R6: start word idle and garbage while busy are not faults
        fault_clr = 1; loc_put = 0; link_pat('0); step("R9 clear");
        fault_clr = 0; link_word(SOP); step("R6 start word");
        lnk_in_put = 1; lnk_in_data = 8'h13; step("R6 busy garbage");
        link_pat('0); step("R6 quiet");
        link_pat('0); step("R6 quiet2");
        // R5: fault code from upstream
        link_word(FC); step("R5 code");
        link_pat('0); step("R5 latch");
        link_pat('0); step("R5 sticky");
        // R9: clear at the edge where a mismatch is judged
        link_pat(8'h80); step("R9 pre");
        fault_clr = 1; link_pat('0); step("R9 clear beats detect");
        fault_clr = 0; link_pat('0); step("R9 after");
        link_pat('0); step("R9 no code");
        // R3: stuck-at pair only
        all_busy(3, "R3 switch");
        full_mode = 0;
        for (int k = 0; k < 7; k++) begin
            loc_put = 0; link_pat('0); step("R3 stuck pair");
        end
        all_busy(3, "R3 switch back");
        full_mode = 1;
        // random traffic
        for (int k = 0; k < 600; k++) begin
            int r = int'($urandom % 100);
            loc_put   = ($urandom % 3) == 0;
            loc_flit  = W'($urandom);
            fault_clr = ($urandom % 40) == 0;
            if (r < 30) begin lnk_in_put = 1; lnk_in_data = W'($urandom); end
            else if (r < 33) link_pat(W'(1) << ($urandom % W));
            else if (r < 35) link_word(FC);
            else if (r < 38) link_word(SOP);
            else link_pat('0);
            step("R2 R4 R7 random");
        end
        // R10: reset mid-run
        rst_n = 0; #1;
        chk("R10 rerst put", 64'(lnk_out_put), 0);
        chk("R10 rerst flags", 64'({up_out_fault, loc_in_fault}), 0);
        m_put = 0; m_data = '0; m_cap_put = 1; m_pend = 0; m_up = 0; m_in = 0;
        m_txi = 0; m_rxi = 0; s_idx = 0;
        @(negedge clk); rst_n = 1;
        for (int k = 0; k < 4; k++) begin
            loc_put = 0; fault_clr = 0; link_pat('0); step("R10 restart");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule